// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Sensing

This block is a memory-mapped general-purpose I/O controller for up to twelve pins. A simple 32-bit register bus drives each pin's output value and its direction. The same bus reads back the pin levels after they have been synchronised to the block clock. Each pin also has its own interrupt detector. The detector can be set to sense a rising edge, a falling edge, either edge, a high level or a low level.

A detected event is recorded as a pending status bit, but only while that pin's interrupt enable is set. Status bits are cleared by writing ones to a clear register. A separate mask register is set and cleared through two write-one registers. The masked view of the status is readable, and its OR drives a single interrupt request line. A soft-reset register holds every register at its reset value while its bit is set. Writing 1 and then 0 to it returns the block to its default state.

The bus is a single-cycle write strobe with a word address. Read data is combinational on the address. Registers sit at 4-byte spacing, and address bits [1:0] are ignored.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register returns 0 (with all pins low), and pin_out, pin_dir and irq are 0.
- R2: A write at 0x18 sets pin_out and a write at 0x20 sets pin_dir (1 = output, 0 = input), both from the next clock. A write at 0x38 stores a pin function select word. Only bits [11:0] of these registers are kept, and bits [31:12] read 0.
- R3: Reading 0x1C returns the pin inputs through a two-stage synchroniser. A change on pin_in is first visible after the second rising clock edge.
- R4: Pin p has a 3-bit mode field. Pins 0 to 7 use the register at 0x24 at bit 4*p. Pins 8 to 11 use the register at 0x28 at bit 4*(p-8). Only the 3-bit fields read back. The codes are 0 = falling edge, 1 = rising edge and 4 = either edge. Codes 5 to 7 detect nothing.
- R5: Code 2 (low level) and code 3 (high level) set status on every cycle in which the synchronised level matches. After a clear, the bit sets again one cycle later if the level still holds.
- R6: A status bit is recorded only while its enable bit at 0x00 is set. Events on a disabled pin leave no status, even after the pin is later enabled.
- R7: Writing ones at 0x0C clears the matching status bits (readable at 0x04). Zero bits have no effect. A clear wins over a detection in the same cycle.
- R8: A one written at 0x10 masks a pin and a one written at 0x14 unmasks it. 0x08 reads status AND NOT mask, and irq is the OR of that view.
- R9: Reads of 0x0C, 0x10, 0x14, 0x3C and the reserved words 0x2C to 0x34 return 0. Writes to the reserved words change nothing.
- R10: Writing 1 at 0x3C (bit 0) holds every register at its reset value, and other writes are ignored while it is held. Writing 0 there releases the block.
- R11: An edge on pin_in sets its status bit at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 12 | Asynchronous pin input levels |
| pin_out | output | 12 | Output drive values |
| pin_dir | output | 12 | Per-pin direction, 1 = output |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the clock edge of the write strobe. Reads are sampled combinationally in the low phase that follows, so a value written is checked in the very next half cycle. Synchronised input data is due after two rising edges, and edge status after three. The bench changes pins on a falling edge and counts edges explicitly: it samples one cycle early to see the old value and at the due edge to see the new one. The level re-arm after a clear is checked in the half cycle after the clear edge, expecting 0, and one edge later, expecting 1. In the random phase every pin pattern is held for four edges before the status is compared. This lets both the old-level and the new-level contributions settle before the comparison.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DATA_W         = 32;
    localparam int ADDR_W         = 6;
    localparam int MODE_W         = 3;
    localparam int MODE_STRIDE    = 4;
    localparam int FIELDS_PER_REG = DATA_W / MODE_STRIDE;
    localparam int SYNC_STAGES    = 2;
    localparam int NUM_WORDS      = 16;
    localparam int IDX_W          = ADDR_W - 2;

    typedef logic [DATA_W-1:0] word_t;

    // Word index of each register; the order is the bus decode.
    typedef enum logic [IDX_W-1:0] {
        RG_ENABLE = 4'd0,
        RG_STATUS = 4'd1,
        RG_MSTAT  = 4'd2,
        RG_CLEAR  = 4'd3,
        RG_MSET   = 4'd4,
        RG_MCLR   = 4'd5,
        RG_OUT    = 4'd6,
        RG_IN     = 4'd7,
        RG_DIR    = 4'd8,
        RG_MODE0  = 4'd9,
        RG_MODE1  = 4'd10,
        RG_RSV0   = 4'd11,
        RG_RSV1   = 4'd12,
        RG_RSV2   = 4'd13,
        RG_FSEL   = 4'd14,
        RG_SRST   = 4'd15
    } reg_idx_e;

    typedef enum logic [MODE_W-1:0] {
        MD_FALL = 3'd0,
        MD_RISE = 3'd1,
        MD_LOW  = 3'd2,
        MD_HIGH = 3'd3,
        MD_BOTH = 3'd4
    } irq_mode_e;

    // Per-pin event decision from the current and previous sample.
    function automatic logic mode_hit(logic [MODE_W-1:0] mode, logic cur, logic prev);
        logic h;
        case (mode)
            MD_FALL: h = prev & ~cur;
            MD_RISE: h = cur & ~prev;
            MD_LOW:  h = ~cur;
            MD_HIGH: h = cur;
            MD_BOTH: h = cur ^ prev;
            default: h = 1'b0;
        endcase
        return h;
    endfunction

    // Bit position of a pin's mode field inside its mode register.
    function automatic int unsigned mode_bitpos(int unsigned pin);
        return (pin % FIELDS_PER_REG) * MODE_STRIDE;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_irq_pkg::*;
#(
    parameter int W      = 12,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPINS-1:0]        cur,
    input  logic [NPINS*MODE_W-1:0] mode_flat,
    output logic [NPINS-1:0]        hit
);

    logic [NPINS-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
        end else begin
            prev <= cur;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign hit[p] = mode_hit(mode_flat[p*MODE_W +: MODE_W], cur[p], prev[p]);
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  reg_idx_e                bus_idx,
    input  logic                    bus_wr,
    input  word_t                   bus_wdata,
    input  logic [NPINS-1:0]        in_data,
    input  logic [NPINS-1:0]        hit,
    output word_t                   rdata,
    output logic [NPINS-1:0]        en_q,
    output logic [NPINS-1:0]        st_q,
    output logic [NPINS-1:0]        msk_st,
    output logic [NPINS-1:0]        out_q,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS*MODE_W-1:0] mode_flat,
    output logic                    srst_q
);

    localparam int PAD = DATA_W - NPINS;

    logic [NPINS-1:0]  mask_q;
    logic [NPINS-1:0]  fsel_q;
    logic [NPINS-1:0]  clr_bits;
    logic [NPINS-1:0]  set_bits;
    logic [NPINS-1:0]  unset_bits;
    logic [MODE_W-1:0] mode_q [NPINS];
    logic [NUM_WORDS-1:0] wstrobe;
    logic              blk_rst;
    word_t             mode_rd0;
    word_t             mode_rd1;
    logic              unused_wdata;

    assign blk_rst      = rst | srst_q;
    assign unused_wdata = ^bus_wdata;

    // One strobe per word; writes are dropped while soft reset is held.
    always_comb begin
        wstrobe = '0;
        if (bus_wr && !srst_q) begin
            wstrobe[bus_idx] = 1'b1;
        end
    end

    assign clr_bits   = wstrobe[RG_CLEAR] ? bus_wdata[NPINS-1:0] : '0;
    assign set_bits   = wstrobe[RG_MSET]  ? bus_wdata[NPINS-1:0] : '0;
    assign unset_bits = wstrobe[RG_MCLR]  ? bus_wdata[NPINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q <= 1'b0;
        end else if (bus_wr && bus_idx == RG_SRST) begin
            srst_q <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            en_q   <= '0;
            st_q   <= '0;
            mask_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
            fsel_q <= '0;
        end else begin
            if (wstrobe[RG_ENABLE]) en_q   <= bus_wdata[NPINS-1:0];
            if (wstrobe[RG_OUT])    out_q  <= bus_wdata[NPINS-1:0];
            if (wstrobe[RG_DIR])    dir_q  <= bus_wdata[NPINS-1:0];
            if (wstrobe[RG_FSEL])   fsel_q <= bus_wdata[NPINS-1:0];
            mask_q <= (mask_q | set_bits) & ~unset_bits;
            st_q   <= (st_q | (hit & en_q)) & ~clr_bits;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_mode
        localparam int       POS  = (p % FIELDS_PER_REG) * MODE_STRIDE;
        localparam reg_idx_e RIDX = (p < FIELDS_PER_REG) ? RG_MODE0 : RG_MODE1;

        always_ff @(posedge clk) begin
            if (blk_rst) begin
                mode_q[p] <= '0;
            end else if (wstrobe[RIDX]) begin
                mode_q[p] <= bus_wdata[POS +: MODE_W];
            end
        end

        assign mode_flat[p*MODE_W +: MODE_W] = mode_q[p];
    end

    always_comb begin
        mode_rd0 = '0;
        mode_rd1 = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < FIELDS_PER_REG) begin
                mode_rd0[mode_bitpos(p) +: MODE_W] = mode_q[p];
            end else begin
                mode_rd1[mode_bitpos(p) +: MODE_W] = mode_q[p];
            end
        end
    end

    assign msk_st = st_q & ~mask_q;

    always_comb begin
        case (bus_idx)
            RG_ENABLE: rdata = {{PAD{1'b0}}, en_q};
            RG_STATUS: rdata = {{PAD{1'b0}}, st_q};
            RG_MSTAT:  rdata = {{PAD{1'b0}}, msk_st};
            RG_OUT:    rdata = {{PAD{1'b0}}, out_q};
            RG_IN:     rdata = {{PAD{1'b0}}, in_data};
            RG_DIR:    rdata = {{PAD{1'b0}}, dir_q};
            RG_MODE0:  rdata = mode_rd0;
            RG_MODE1:  rdata = mode_rd1;
            RG_FSEL:   rdata = {{PAD{1'b0}}, fsel_q};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_dir,
    output logic              irq
);

    reg_idx_e                bus_idx;
    logic [NPINS-1:0]        in_data;
    logic [NPINS-1:0]        hit;
    logic [NPINS-1:0]        en_q;
    logic [NPINS-1:0]        st_q;
    logic [NPINS-1:0]        msk_st;
    logic [NPINS*MODE_W-1:0] mode_flat;
    logic                    srst_q;
    logic                    unused_addr;

    assign bus_idx     = reg_idx_e'(bus_addr[ADDR_W-1:2]);
    assign unused_addr = ^bus_addr[1:0];

    gpio_in_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (in_data)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .clk       (clk),
        .rst       (rst),
        .cur       (in_data),
        .mode_flat (mode_flat),
        .hit       (hit)
    );

    gpio_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_idx   (bus_idx),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .in_data   (in_data),
        .hit       (hit),
        .rdata     (bus_rdata),
        .en_q      (en_q),
        .st_q      (st_q),
        .msk_st    (msk_st),
        .out_q     (pin_out),
        .dir_q     (pin_dir),
        .mode_flat (mode_flat),
        .srst_q    (srst_q)
    );

    assign irq = |msk_st;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NPINS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_idx,
    input logic             bus_wr,
    input logic [NPINS-1:0] bus_wlo,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_dir,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] st_q,
    input logic [NPINS-1:0] msk_st,
    input logic             irq,
    input logic             srst_q
);

    // R2
    out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_idx == 4'd6 && !srst_q) |=> (pin_out == $past(bus_wlo)));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_idx == 4'd8 && !srst_q) |=> (pin_dir == $past(bus_wlo)));

    // R6
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_idx == 4'd3) |=> ((st_q & $past(bus_wlo)) == '0));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_idx == 4'd4) |=> ((msk_st & $past(bus_wlo)) == '0));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (pin_out == '0 && pin_dir == '0 && en_q == '0 && st_q == '0 && !irq));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_idx (bus_addr[5:2]),
    .bus_wr  (bus_wr),
    .bus_wlo (bus_wdata[NPINS-1:0]),
    .pin_out (pin_out),
    .pin_dir (pin_dir),
    .en_q    (en_q),
    .st_q    (st_q),
    .msk_st  (msk_st),
    .irq     (irq),
    .srst_q  (srst_q)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;

    localparam int NP = 12;
    localparam int A_EN = 0, A_ST = 1, A_MST = 2, A_CLR = 3, A_MSET = 4, A_MCLR = 5;
    localparam int A_OUT = 6, A_IN = 7, A_DIR = 8, A_MD0 = 9, A_MD1 = 10, A_FSEL = 14, A_SRST = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_dir;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_dir   (pin_dir),
        .irq       (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Entered and left at a falling edge; the write lands on the rising edge between.
    task automatic wr(int idx, logic [31:0] d);
        bus_addr  = 6'(idx * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    // Samples in the low phase, then moves on to the next falling edge.
    task automatic rd(int idx, output logic [31:0] d);
        bus_addr = 6'(idx * 4);
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] exp_status(logic [NP-1:0] en, logic [47:0] md,
                                                 logic [NP-1:0] o, logic [NP-1:0] n);
        logic [NP-1:0] e;
        for (int p = 0; p < NP; p++) begin
            case (md[p*4 +: 3])
                3'd0:    e[p] = o[p] & ~n[p];
                3'd1:    e[p] = n[p] & ~o[p];
                3'd2:    e[p] = ~o[p] | ~n[p];
                3'd3:    e[p] = o[p] | n[p];
                3'd4:    e[p] = o[p] ^ n[p];
                default: e[p] = 1'b0;
            endcase
        end
        return e & en;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0]   v;
        logic [NP-1:0] en, msk, old_p, new_p, e;
        logic [47:0]   md;
        void'($urandom(32'd4242));

        step(4);
        rst = 1'b0;
        step(1);

        // R1: reset values
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk($sformatf("R1 reg %0d after reset", i), v, 32'h0);
        end
        chk("R1 pin_out", 32'(pin_out), 32'h0);
        chk("R1 pin_dir", 32'(pin_dir), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2: output, direction, function select
        wr(A_OUT, 32'hFFFF_FABC);
        chk("R2 pin_out", 32'(pin_out), 32'h0000_0ABC);
        rd(A_OUT, v);  chk("R2 out readback", v, 32'h0000_0ABC);
        wr(A_DIR, 32'hFFFF_0F0F);
        chk("R2 pin_dir", 32'(pin_dir), 32'h0000_0F0F);
        rd(A_DIR, v);  chk("R2 dir readback", v, 32'h0000_0F0F);
        wr(A_FSEL, 32'h1234_55A5);
        rd(A_FSEL, v); chk("R2 fsel readback", v, 32'h0000_05A5);

        // R3: two-stage input synchroniser
        pin_in = 12'h9C3;
        step(1);
        rd(A_IN, v);   chk("R3 input after one edge", v, 32'h0);
        rd(A_IN, v);   chk("R3 input after two edges", v, 32'h0000_09C3);
        pin_in = 12'h000;
        step(4);

        // R4: mode field packing
        wr(A_MD0, 32'hFFFF_FFFF);
        rd(A_MD0, v);  chk("R4 mode0 readback", v, 32'h7777_7777);
        wr(A_MD1, 32'hFFFF_FFFF);
        rd(A_MD1, v);  chk("R4 mode1 readback", v, 32'h0000_7777);
        wr(A_MD0, 32'h0);
        wr(A_MD1, 32'h0);

        // R11: rising edge on pin 0 (code 1 at bit 0) lands on the third edge
        wr(A_MD0, 32'h0000_0001);
        wr(A_EN, 32'h0000_0001);
        wr(A_CLR, 32'hFFF);
        pin_in[0] = 1'b1;
        step(2);
        rd(A_ST, v);   chk("R11 status before third edge", v, 32'h0);
        rd(A_ST, v);   chk("R11 status at third edge", v, 32'h1);
        chk("R11 irq raised", 32'(irq), 32'h1);

        // R5: high level (code 3) on pin 1 re-arms after a clear
        wr(A_MD0, 32'h0000_0031);
        wr(A_EN, 32'h0000_0003);
        pin_in[1] = 1'b1;
        step(4);
        wr(A_CLR, 32'h0000_0002);
        rd(A_ST, v);   chk("R5 level cleared", v & 32'h2, 32'h0);
        rd(A_ST, v);   chk("R5 level re-set next cycle", v & 32'h2, 32'h2);

        // R7: zero write has no effect, then clear pin 0
        wr(A_CLR, 32'h0);
        rd(A_ST, v);   chk("R7 zero clear no effect", v & 32'h1, 32'h1);
        wr(A_CLR, 32'h1);
        rd(A_ST, v);   chk("R7 pin0 cleared", v & 32'h1, 32'h0);

        // R6: rising edge on a disabled pin 2 leaves no status
        wr(A_MD0, 32'h0000_0131);
        pin_in[2] = 1'b1;
        step(5);
        wr(A_EN, 32'h0000_0007);
        step(2);
        rd(A_ST, v);   chk("R6 disabled pin no status", v & 32'h4, 32'h0);

        // R8: mask pin 1 (level still active) and unmask it
        wr(A_MSET, 32'h0000_0002);
        rd(A_MST, v);  chk("R8 masked view hides pin1", v, 32'h0);
        chk("R8 irq low when masked", 32'(irq), 32'h0);
        rd(A_ST, v);   chk("R8 raw status keeps pin1", v & 32'h2, 32'h2);
        wr(A_MCLR, 32'h0000_0002);
        rd(A_MST, v);  chk("R8 unmasked view", v & 32'h2, 32'h2);
        chk("R8 irq high when unmasked", 32'(irq), 32'h1);

        // R9: write-only and reserved words read 0, reserved writes ignored
        wr(11, 32'hFFFF_FFFF);
        wr(12, 32'hFFFF_FFFF);
        wr(13, 32'hFFFF_FFFF);
        foreach (v[i]) begin end
        rd(A_CLR, v);  chk("R9 clear reads 0", v, 32'h0);
        rd(A_MSET, v); chk("R9 mask set reads 0", v, 32'h0);
        rd(A_MCLR, v); chk("R9 mask clear reads 0", v, 32'h0);
        rd(A_SRST, v); chk("R9 soft reset reads 0", v, 32'h0);
        rd(11, v);     chk("R9 reserved 0x2C", v, 32'h0);
        rd(12, v);     chk("R9 reserved 0x30", v, 32'h0);
        rd(13, v);     chk("R9 reserved 0x34", v, 32'h0);
        rd(A_EN, v);   chk("R9 enable unchanged", v, 32'h7);
        rd(A_OUT, v);  chk("R9 out unchanged", v, 32'hABC);
        rd(A_MD0, v);  chk("R9 mode0 unchanged", v, 32'h131);
        rd(A_MD1, v);  chk("R9 mode1 unchanged", v, 32'h0);
        rd(A_FSEL, v); chk("R9 fsel unchanged", v, 32'h5A5);

        // R4 R5 R6 R8: random configurations against the bench model
        for (int it = 0; it < 60; it++) begin
            en  = NP'($urandom);
            msk = NP'($urandom);
            md  = '0;
            for (int p = 0; p < NP; p++) md[p*4 +: 3] = 3'($urandom % 8);
            old_p = NP'($urandom);
            new_p = (it % 3 == 0) ? old_p : NP'($urandom);
            wr(A_EN, 32'(en));
            wr(A_MD0, md[31:0]);
            wr(A_MD1, {16'h0, md[47:32]});
            wr(A_MCLR, 32'hFFF);
            wr(A_MSET, 32'(msk));
            pin_in = old_p;
            step(4);
            wr(A_CLR, 32'hFFF);
            pin_in = new_p;
            step(4);
            e = exp_status(en, md, old_p, new_p);
            rd(A_ST, v);  chk($sformatf("R4 random status it%0d", it), v, 32'(e));
            rd(A_MST, v); chk($sformatf("R8 random masked it%0d", it), v, 32'(e & ~msk));
            chk($sformatf("R8 random irq it%0d", it), 32'(irq), 32'(|(e & ~msk)));
        end

        // R10: soft reset hold and release
        wr(A_OUT, 32'h0F0);
        wr(A_DIR, 32'hF00);
        wr(A_SRST, 32'h1);
        wr(A_OUT, 32'h0FF);
        rd(A_OUT, v);  chk("R10 write ignored during hold", v, 32'h0);
        wr(A_SRST, 32'h0);
        for (int i = 0; i < 16; i++) begin
            if (i != A_IN) begin
                rd(i, v);
                chk($sformatf("R10 reg %0d after soft reset", i), v, 32'h0);
            end
        end
        chk("R10 pin_out", 32'(pin_out), 32'h0);
        chk("R10 pin_dir", 32'(pin_dir), 32'h0);
        chk("R10 irq", 32'(irq), 32'h0);
        wr(A_OUT, 32'h123);
        chk("R10 writes work after release", 32'(pin_out), 32'h123);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule